// File: doc/BRIEF.md
# Program Memory Table Access Guard

This block sits between a processor's table read/write port and its flash program memory. For every table access it works out which protection region the target address falls in and which region the executing instruction sits in, then decides whether the access may go ahead. Allowed reads pass the flash data through. Denied reads return zero. Allowed writes are forwarded to the flash write strobe, and denied writes are dropped. Every denial produces a single-cycle violation pulse.

The guard also owns the protection configuration. Each region has three bits: one gating external programmer access, one gating table writes, and one gating table reads from foreign code. There are also two data-memory bits and one bit that locks the configuration itself. A configuration write can only clear bits. Bits return to 1 only through an erase request that arrives on the programming path, either for one region or for the whole chip. A second, external access port is gated only by the programmer-access bits.

All outputs are registered, so each result appears one clock after the request.

Top module: `tbl_guard`

## Requirements
- R1: Regions are decoded from the address as follows. Code 0 is the boot region, 000000h–0007FFh. Codes 1 to 4 are blocks 0 to 3, which are 16 KiB blocks bounded at 000800h, 004000h, 008000h, 00C000h and 00FFFFh. Code 5 means unimplemented, for any address at or above 010000h.
- R2: A table write to a region whose write-enable bit (cfg bit 5+code) is 0 is dropped, whatever the program counter. An allowed write raises `fl_we` one cycle later, carrying the request's address and data.
- R3: If a region's read-enable bit (cfg bit 10+code) is 0, a table read is allowed only when the program counter decodes to the same region as the target.
- R4: A denied table read returns all zeros on `tbl_rdata`. An allowed read returns the `fl_rdata` value sampled with the request, one cycle later.
- R5: Table reads at unimplemented addresses return zero, and table writes there are dropped.
- R6: Programmer-access bits (cfg bit code) have no effect on table accesses. On the external port, a read from a region whose bit is 0 returns zero and a write there does not raise `ext_we`.
- R7: A configuration write sets the register to the old value AND `cfg_wdata`. Writing 1 to a bit that is 0 leaves it 0.
- R8: While the configuration lock bit (cfg bit 17) is 0, configuration writes are ignored. Bits 15 and 16 are the data-memory access and write bits.
- R9: A block erase with region code `prog_erase_sel` sets that region's three bits to 1 and leaves every other bit unchanged. Codes above 4 do nothing.
- R10: An erase that arrives in the same cycle as a configuration write wins on every bit it sets. A full erase sets all 18 bits to 1.
- R11: Each denied table or external access gives a `violation` pulse exactly one cycle long. Allowed accesses give none.
- R12: After reset, every configuration bit is 1, and `fl_we`, `ext_we`, `violation` and the read data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_rd | input | 1 | Table read request |
| tbl_wr | input | 1 | Table write request |
| tbl_addr | input | 24 | Table pointer target address |
| pc | input | 24 | Address of the executing table instruction |
| tbl_wdata | input | 8 | Table write data |
| fl_rdata | input | 8 | Flash data at tbl_addr |
| tbl_rdata | output | 8 | Masked table read data |
| fl_we | output | 1 | Flash write strobe for table writes |
| fl_waddr | output | 24 | Flash write address |
| fl_wdata | output | 8 | Flash write data |
| ext_rd | input | 1 | External programmer read request |
| ext_wr | input | 1 | External programmer write request |
| ext_addr | input | 24 | External access address |
| ext_fl_rdata | input | 8 | Flash data at ext_addr |
| ext_rdata | output | 8 | Masked external read data |
| ext_we | output | 1 | Allowed external write strobe |
| cfg_we | input | 1 | Configuration write (clear-only) |
| cfg_wdata | input | 18 | Configuration write value |
| prog_erase_all | input | 1 | Full chip erase from programming path |
| prog_erase_blk | input | 1 | Single region erase from programming path |
| prog_erase_sel | input | 3 | Region code for a block erase |
| cfg_q | output | 18 | Current protection configuration |
| violation | output | 1 | One-cycle pulse for a denied access |

## Verification
Two functions can meet in one cycle: a clear-only configuration write and an erase from the programming path. The bench provokes this by asserting `cfg_we` and an erase on the same clock edge. In the first case a block erase is chosen whose region overlaps the bits being cleared. In the second case a full erase is used. Reading `cfg_q` afterwards must show the erased bits at 1 and any clear outside the erased region still applied.

// File: rtl/tbl_guard_pkg.sv
package tbl_guard_pkg;
  function automatic int cp_pos(int nreg, int r);
    return r + 0 * nreg;
  endfunction
  function automatic int wr_pos(int nreg, int r);
    return nreg + r;
  endfunction
  function automatic int rd_pos(int nreg, int r);
    return 2 * nreg + r;
  endfunction
  function automatic int cfg_width(int nreg);
    return 3 * nreg + 3;
  endfunction
endpackage

// File: rtl/tbl_guard_decode.sv
module tbl_guard_decode #(
  parameter int ADDR_W     = 24,
  parameter int NUM_BLK    = 4,
  parameter int BOOT_BYTES = 2048,
  parameter int BLK_BITS   = 14,
  parameter int RC_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RC_W-1:0]   rc
);
  localparam int USER_END = NUM_BLK << BLK_BITS;
  localparam logic [RC_W-1:0] UNIMPL = RC_W'(NUM_BLK + 1);

  always_comb begin
    if (addr < ADDR_W'(BOOT_BYTES))
      rc = '0;
    else if (addr < ADDR_W'(USER_END))
      rc = RC_W'(addr >> BLK_BITS) + RC_W'(1);
    else
      rc = UNIMPL;
  end
endmodule

// File: rtl/tbl_guard_prot_reg.sv
module tbl_guard_prot_reg
  import tbl_guard_pkg::*;
#(
  parameter int NREG  = 5,
  parameter int RC_W  = 3,
  parameter int CFG_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             erase_all,
  input  logic             erase_blk,
  input  logic [RC_W-1:0]  erase_sel,
  output logic [CFG_W-1:0] q
);
  localparam int LOCK_POS = CFG_W - 1;
  logic [CFG_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (cfg_we && q[LOCK_POS])
      nxt = q & cfg_wdata;
    if (erase_all)
      nxt = '1;
    else if (erase_blk && (erase_sel < RC_W'(NREG))) begin
      nxt[cp_pos(NREG, int'(erase_sel))] = 1'b1;
      nxt[wr_pos(NREG, int'(erase_sel))] = 1'b1;
      nxt[rd_pos(NREG, int'(erase_sel))] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= nxt;
  end

  // R7: without an erase, no bit can go from 0 to 1
  assert_clear_only_R7: assert property (@(posedge clk) disable iff (rst)
    (!erase_all && !erase_blk) |=> ((q & ~$past(q)) == '0));

  // R8: a locked configuration ignores writes
  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !q[LOCK_POS] && !erase_all && !erase_blk) |=> (q == $past(q)));

  // R10: full erase restores every bit regardless of a concurrent write
  assert_full_erase_R10: assert property (@(posedge clk) disable iff (rst)
    erase_all |=> (&q));
endmodule

// File: rtl/tbl_guard_perm.sv
module tbl_guard_perm
  import tbl_guard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int NREG   = 5,
  parameter int RC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3*NREG-1:0] prot,
  input  logic              tbl_rd,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic [RC_W-1:0]   rc_tgt,
  input  logic [RC_W-1:0]   rc_pc,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic [DATA_W-1:0] ext_fl_rdata,
  input  logic [RC_W-1:0]   rc_ext,
  output logic [DATA_W-1:0] tbl_rdata,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_waddr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              ext_we,
  output logic              violation
);
  localparam logic [RC_W-1:0] UNIMPL = RC_W'(NREG);

  logic tgt_impl, ext_impl;
  logic rd_bit, wr_bit, cp_bit;
  logic rd_ok, wr_ok, xrd_ok, xwr_ok, deny;

  assign tgt_impl = (rc_tgt != UNIMPL);
  assign ext_impl = (rc_ext != UNIMPL);

  always_comb begin
    rd_bit = 1'b0;
    wr_bit = 1'b0;
    cp_bit = 1'b0;
    if (tgt_impl) begin
      rd_bit = prot[rd_pos(NREG, int'(rc_tgt))];
      wr_bit = prot[wr_pos(NREG, int'(rc_tgt))];
    end
    if (ext_impl)
      cp_bit = prot[cp_pos(NREG, int'(rc_ext))];
  end

  assign rd_ok  = tbl_rd && tgt_impl && (rd_bit || (rc_pc == rc_tgt));
  assign wr_ok  = tbl_wr && tgt_impl && wr_bit;
  assign xrd_ok = ext_rd && cp_bit;
  assign xwr_ok = ext_wr && cp_bit;
  assign deny   = (tbl_rd && !rd_ok) || (tbl_wr && !wr_ok) ||
                  (ext_rd && !xrd_ok) || (ext_wr && !xwr_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_rdata <= '0;
      fl_we     <= 1'b0;
      fl_waddr  <= '0;
      fl_wdata  <= '0;
      ext_rdata <= '0;
      ext_we    <= 1'b0;
      violation <= 1'b0;
    end else begin
      tbl_rdata <= rd_ok ? fl_rdata : '0;
      fl_we     <= wr_ok;
      fl_waddr  <= tbl_addr;
      fl_wdata  <= tbl_wdata;
      ext_rdata <= xrd_ok ? ext_fl_rdata : '0;
      ext_we    <= xwr_ok;
      violation <= deny;
    end
  end

  // R2: write to a write-protected region is dropped and flagged
  assert_wr_blocked_R2: assert property (@(posedge clk) disable iff (rst)
    (tbl_wr && tgt_impl && !prot[NREG + int'(rc_tgt)]) |=> (!fl_we && violation));

  // R3: code reading its own region always sees flash data
  assert_same_region_R3: assert property (@(posedge clk) disable iff (rst)
    (tbl_rd && tgt_impl && (rc_pc == rc_tgt)) |=> (tbl_rdata == $past(fl_rdata)));

  // R5: unimplemented addresses give zero and no write
  assert_unimpl_R5: assert property (@(posedge clk) disable iff (rst)
    ((tbl_rd || tbl_wr) && !tgt_impl) |=> (tbl_rdata == '0 && !fl_we && violation));

  // R6: external read of a protected region returns zero
  assert_ext_masked_R6: assert property (@(posedge clk) disable iff (rst)
    (ext_rd && ext_impl && !prot[int'(rc_ext)]) |=> (ext_rdata == '0));

  // R11: no request in a cycle means no violation in the next
  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (!tbl_rd && !tbl_wr && !ext_rd && !ext_wr) |=> !violation);
endmodule

// File: rtl/tbl_guard.sv
module tbl_guard
  import tbl_guard_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int NUM_BLK    = 4,
  parameter int BOOT_BYTES = 2048,
  parameter int BLK_BITS   = 14,
  localparam int NREG      = NUM_BLK + 1,
  localparam int RC_W      = $clog2(NREG + 1),
  localparam int CFG_W     = 3 * NREG + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_rd,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] tbl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic [DATA_W-1:0] tbl_rdata,
  output logic              fl_we,
  output logic [ADDR_W-1:0] fl_waddr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              ext_rd,
  input  logic              ext_wr,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_fl_rdata,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              ext_we,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              prog_erase_all,
  input  logic              prog_erase_blk,
  input  logic [RC_W-1:0]   prog_erase_sel,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              violation
);
  logic [ADDR_W-1:0] dec_addr [3];
  logic [RC_W-1:0]   dec_rc   [3];

  assign dec_addr[0] = tbl_addr;
  assign dec_addr[1] = pc;
  assign dec_addr[2] = ext_addr;

  for (genvar g = 0; g < 3; g++) begin : g_dec
    tbl_guard_decode #(
      .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BOOT_BYTES(BOOT_BYTES),
      .BLK_BITS(BLK_BITS), .RC_W(RC_W)
    ) u_dec (
      .addr(dec_addr[g]),
      .rc  (dec_rc[g])
    );
  end

  tbl_guard_prot_reg #(.NREG(NREG), .RC_W(RC_W), .CFG_W(CFG_W)) u_prot (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .erase_all(prog_erase_all),
    .erase_blk(prog_erase_blk),
    .erase_sel(prog_erase_sel),
    .q        (cfg_q)
  );

  tbl_guard_perm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG), .RC_W(RC_W)) u_perm (
    .clk         (clk),
    .rst         (rst),
    .prot        (cfg_q[3*NREG-1:0]),
    .tbl_rd      (tbl_rd),
    .tbl_wr      (tbl_wr),
    .tbl_addr    (tbl_addr),
    .tbl_wdata   (tbl_wdata),
    .fl_rdata    (fl_rdata),
    .rc_tgt      (dec_rc[0]),
    .rc_pc       (dec_rc[1]),
    .ext_rd      (ext_rd),
    .ext_wr      (ext_wr),
    .ext_fl_rdata(ext_fl_rdata),
    .rc_ext      (dec_rc[2]),
    .tbl_rdata   (tbl_rdata),
    .fl_we       (fl_we),
    .fl_waddr    (fl_waddr),
    .fl_wdata    (fl_wdata),
    .ext_rdata   (ext_rdata),
    .ext_we      (ext_we),
    .violation   (violation)
  );
endmodule

// File: tb/tbl_guard_bench.sv
`timescale 1ns/100ps
module tbl_guard_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        tbl_rd, tbl_wr;
  logic [23:0] tbl_addr, pc;
  logic [7:0]  tbl_wdata, fl_rdata;
  logic [7:0]  tbl_rdata;
  logic        fl_we;
  logic [23:0] fl_waddr;
  logic [7:0]  fl_wdata;
  logic        ext_rd, ext_wr;
  logic [23:0] ext_addr;
  logic [7:0]  ext_fl_rdata, ext_rdata;
  logic        ext_we;
  logic        cfg_we;
  logic [17:0] cfg_wdata;
  logic        prog_erase_all, prog_erase_blk;
  logic [2:0]  prog_erase_sel;
  logic [17:0] cfg_q;
  logic        violation;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tbl_guard u_tbl_guard (
    .clk(clk), .rst(rst), .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .tbl_addr(tbl_addr),
    .pc(pc), .tbl_wdata(tbl_wdata), .fl_rdata(fl_rdata), .tbl_rdata(tbl_rdata),
    .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata), .ext_rd(ext_rd),
    .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_fl_rdata(ext_fl_rdata),
    .ext_rdata(ext_rdata), .ext_we(ext_we), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .prog_erase_all(prog_erase_all), .prog_erase_blk(prog_erase_blk),
    .prog_erase_sel(prog_erase_sel), .cfg_q(cfg_q), .violation(violation)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tbl_rd = 0; tbl_wr = 0; tbl_addr = 0; pc = 0; tbl_wdata = 0; fl_rdata = 0;
    ext_rd = 0; ext_wr = 0; ext_addr = 0; ext_fl_rdata = 0;
    cfg_we = 0; cfg_wdata = '1; prog_erase_all = 0; prog_erase_blk = 0; prog_erase_sel = 0;
  endtask

  // read: drive on a falling edge, result registered at the rising edge, sample next falling edge
  task automatic do_read(input logic [23:0] p, input logic [23:0] a, input logic [7:0] d,
                         input logic [7:0] exp_d, input logic exp_v, input string tag);
    @(negedge clk);
    tbl_rd = 1; pc = p; tbl_addr = a; fl_rdata = d;
    @(negedge clk);
    idle_inputs();
    check({tag, " rdata"}, 32'(tbl_rdata), 32'(exp_d));
    check({tag, " violation"}, 32'(violation), 32'(exp_v));
  endtask

  task automatic do_write(input logic [23:0] p, input logic [23:0] a, input logic [7:0] d,
                          input logic exp_we, input string tag);
    @(negedge clk);
    tbl_wr = 1; pc = p; tbl_addr = a; tbl_wdata = d;
    @(negedge clk);
    idle_inputs();
    check({tag, " fl_we"}, 32'(fl_we), 32'(exp_we));
    check({tag, " violation"}, 32'(violation), 32'(!exp_we));
    if (exp_we) begin
      check({tag, " waddr"}, 32'(fl_waddr), 32'(a));
      check({tag, " wdata"}, 32'(fl_wdata), 32'(d));
    end
  endtask

  task automatic do_cfg(input logic [17:0] w, input logic all, input logic blk,
                        input logic [2:0] sel, input logic [17:0] exp_q, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = w; prog_erase_all = all; prog_erase_blk = blk; prog_erase_sel = sel;
    @(negedge clk);
    idle_inputs();
    check({tag, " cfg_q"}, 32'(cfg_q), 32'(exp_q));
  endtask

  task automatic do_erase(input logic all, input logic [2:0] sel,
                          input logic [17:0] exp_q, input string tag);
    @(negedge clk);
    prog_erase_all = all; prog_erase_blk = !all; prog_erase_sel = sel;
    @(negedge clk);
    idle_inputs();
    check({tag, " cfg_q"}, 32'(cfg_q), 32'(exp_q));
  endtask

  task automatic do_ext(input logic wr, input logic [23:0] a, input logic [7:0] d,
                        input logic ok, input string tag);
    @(negedge clk);
    ext_rd = !wr; ext_wr = wr; ext_addr = a; ext_fl_rdata = d;
    @(negedge clk);
    idle_inputs();
    if (wr) check({tag, " ext_we"}, 32'(ext_we), 32'(ok));
    else    check({tag, " ext_rdata"}, 32'(ext_rdata), ok ? 32'(d) : 32'h0);
    check({tag, " violation"}, 32'(violation), 32'(!ok));
  endtask

  task automatic t_reset();
    check("R12 cfg reset", 32'(cfg_q), 32'h3FFFF);
    check("R12 fl_we reset", 32'(fl_we), 32'h0);
    check("R12 ext_we reset", 32'(ext_we), 32'h0);
    check("R12 violation reset", 32'(violation), 32'h0);
    check("R12 rdata reset", 32'(tbl_rdata), 32'h0);
  endtask

  task automatic t_read_map();
    do_cfg(~18'h00800, 0, 0, 0, 18'h3F7FF, "R3 clear block0 read bit");
    do_read(24'h003FFE, 24'h0008FF, 8'hA5, 8'hA5, 0, "R3 same block read");
    do_read(24'h0007FE, 24'h000800, 8'h5A, 8'h00, 1, "R1 R4 boot pc reads block0 start");
    do_read(24'h0007FE, 24'h0007FF, 8'h3C, 8'h3C, 0, "R1 boot top unprotected");
    do_read(24'h004000, 24'h003FFF, 8'h77, 8'h00, 1, "R1 R4 block1 pc reads block0 end");
    do_read(24'h003FFE, 24'h004000, 8'h91, 8'h91, 0, "R1 block1 start readable");
  endtask

  task automatic t_write_guard();
    do_cfg(~18'h00040, 0, 0, 0, 18'h3F7BF, "R2 clear block0 write bit");
    do_write(24'h003FFE, 24'h0008FF, 8'h12, 0, "R2 own-block write blocked");
    do_write(24'h00BFFE, 24'h00BFFE, 8'h34, 1, "R2 block2 write allowed");
    do_write(24'h000000, 24'h000100, 8'h56, 1, "R2 boot write allowed");
  endtask

  task automatic t_pulse();
    do_write(24'h000000, 24'h000900, 8'h01, 0, "R11 denied write");
    @(negedge clk);
    check("R11 pulse one cycle", 32'(violation), 32'h0);
  endtask

  task automatic t_unimpl();
    do_read(24'h010000, 24'h010000, 8'hEE, 8'h00, 1, "R5 unimpl read");
    do_write(24'h000000, 24'h01FFFF, 8'hEE, 0, "R5 unimpl write");
    do_read(24'h00FFF0, 24'h00FFFF, 8'h6B, 8'h6B, 0, "R1 R5 last user byte");
  endtask

  task automatic t_clear_only();
    do_cfg(18'h3FFFF, 0, 0, 0, 18'h3F7BF, "R7 write ones ignored");
  endtask

  task automatic t_ext();
    do_cfg(~18'h00008, 0, 0, 0, 18'h3F7B7, "R6 clear block2 cp bit");
    do_read(24'h000000, 24'h008000, 8'hC3, 8'hC3, 0, "R6 cp no effect on table read");
    do_write(24'h000000, 24'h008001, 8'hC4, 1, "R6 cp no effect on table write");
    do_ext(0, 24'h008000, 8'h99, 0, "R6 ext read protected");
    do_ext(1, 24'h008000, 8'h99, 0, "R6 ext write protected");
    do_ext(0, 24'h00C000, 8'h88, 1, "R6 ext read open");
    do_ext(1, 24'h00C000, 8'h88, 1, "R6 ext write open");
  endtask

  task automatic t_blk_erase();
    do_erase(0, 3'd1, 18'h3FFF7, "R9 block0 erase");
    do_erase(0, 3'd6, 18'h3FFF7, "R9 invalid code ignored");
    do_read(24'h000000, 24'h000800, 8'h4D, 8'h4D, 0, "R9 block0 readable after erase");
  endtask

  task automatic t_collision();
    do_cfg(~18'h00011, 0, 1, 3'd4, 18'h3FFF6, "R10 block erase beats clear");
    do_cfg(~18'h00004, 1, 0, 0, 18'h3FFFF, "R10 full erase beats clear");
  endtask

  task automatic t_lock();
    do_cfg(~18'h20000, 0, 0, 0, 18'h1FFFF, "R8 clear lock");
    do_cfg(~18'h00001, 0, 0, 0, 18'h1FFFF, "R8 locked write ignored");
    do_erase(1, 3'd0, 18'h3FFFF, "R8 R10 erase unlocks");
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_map();
    t_write_guard();
    t_pulse();
    t_unimpl();
    t_clear_only();
    t_ext();
    t_blk_erase();
    t_collision();
    t_lock();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule